// File: doc/BRIEF.md
# Page-Write Buffer Controller for a Byte-Addressed Non-Volatile Bank

This block sits below a serial-bus transaction layer and gathers the data bytes of one write transaction into a 16-byte page buffer. The bank it serves holds 256 bytes arranged as 16 pages of 16 bytes. The transaction layer gives it three strobes: an address strobe with an 8-bit byte address, a data strobe with one data byte, and a STOP strobe. Data bytes land at successive positions inside the addressed page. The position wraps inside the page, so bytes past the sixteenth overwrite the bytes loaded earlier at the same positions.

When STOP arrives with at least one byte loaded, the block starts a timed internal write cycle and raises `busy`. The slave-address matcher uses `busy` to withhold its acknowledge, so a master can poll for the end of the cycle. When the count runs out, only the loaded positions are written to the storage model and the buffer is emptied. A combinational read port lets the rest of the device read the storage.

Top module: `pwb_top`

## Requirements
- R1: After reset every storage byte reads 0xFF and `busy` is low.
- R2: An accepted address strobe takes the page from `addr[7:4]` and the start position from `addr[3:0]`, and drops any bytes that were loaded but not yet committed.
- R3: Each accepted data byte is placed at the current position, and the position then advances by one modulo 16, so writes never leave the addressed page.
- R4: A data byte loaded at a position that already holds a loaded byte replaces it. Only the last value is written.
- R5: A commit writes only the positions loaded since the last address strobe or commit. All other bytes of the page keep their contents.
- R6: An accepted STOP with at least one byte loaded raises `busy` on the following clock edge, and `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R7: The storage does not change while `busy` is high. The new bytes are readable in the same cycle in which `busy` is first seen low again.
- R8: An accepted STOP with no bytes loaded leaves `busy` low and the storage unchanged.
- R9: While `busy` is high, address, data and STOP strobes are all ignored.
- R10: After a commit the loaded set is empty, and the page and the next position are kept. A later data byte sent without an address strobe continues from there, and a STOP with nothing loaded starts nothing.
- R11: `rd_data` always shows the storage byte at `rd_addr`, with no clock delay.
- R12: When several strobes are valid in one cycle, only one is acted on. The address strobe has priority, then data, then STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Start-address strobe |
| addr | input | 8 | Byte address, page in [7:4], position in [3:0] |
| data_vld | input | 1 | Data-byte strobe |
| data | input | 8 | Data byte |
| stop_vld | input | 1 | STOP strobe |
| rd_addr | input | 8 | Storage read address |
| rd_data | output | 8 | Storage byte at `rd_addr` |
| busy | output | 1 | Internal write cycle in progress; the address must not be acknowledged |

## Verification
A wrong position pointer or a stale valid mask does not show at the ports until the commit. At that point some byte of the page reads back wrong in the cycle in which `busy` falls. An error in the write-cycle counter shows at once, as `busy` rising or falling one or more cycles away from the expected edge. A commit that fires early shows up as the storage changing while `busy` is still high. The bench keeps its own model of storage and busy and compares against it on every clock, so each of these faults is caught in the cycle in which it first reaches a port.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int ADDR_W     = 8;
    localparam int POS_W      = 4;
    localparam int PAGE_W     = ADDR_W - POS_W;
    localparam int PAGE_BYTES = 1 << POS_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam logic [7:0] ERASED = 8'hFF;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [POS_W-1:0]  pos;
    } baddr_t;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_ADDR = 2'd1,
        SK_DATA = 2'd2,
        SK_STOP = 2'd3
    } strobe_e;

    function automatic baddr_t split_addr(input logic [ADDR_W-1:0] a);
        baddr_t r;
        r.page = a[ADDR_W-1:POS_W];
        r.pos  = a[POS_W-1:0];
        return r;
    endfunction

    // Address beats data beats STOP when they coincide.
    function automatic strobe_e pick_strobe(input logic a, input logic d, input logic s);
        if (a)      return SK_ADDR;
        else if (d) return SK_DATA;
        else if (s) return SK_STOP;
        else        return SK_NONE;
    endfunction
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer
    import pwb_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  strobe_e                         kind,
    input  logic                            accept,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [7:0]                      data,
    input  logic                            commit,
    output logic [PAGE_W-1:0]               page_o,
    output logic [PAGE_BYTES-1:0]           mask_o,
    output logic [PAGE_BYTES-1:0][7:0]      bytes_o
);
    baddr_t                       ptr_q;
    logic [PAGE_BYTES-1:0]        mask_q;
    logic [PAGE_BYTES-1:0][7:0]   buf_q;
    logic                         take_addr, take_data;

    assign take_addr = accept && (kind == SK_ADDR);
    assign take_data = accept && (kind == SK_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take_addr) begin
            ptr_q <= split_addr(addr);
        end else if (take_data) begin
            ptr_q.pos <= ptr_q.pos + 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
            logic hit;
            assign hit = take_data && (ptr_q.pos == POS_W'(g));
            always_ff @(posedge clk) begin
                if (rst || commit) begin
                    mask_q[g] <= 1'b0;
                    buf_q[g]  <= '0;
                end else if (take_addr) begin
                    mask_q[g] <= 1'b0;
                end else if (hit) begin
                    mask_q[g] <= 1'b1;
                    buf_q[g]  <= data;
                end
            end
        end
    endgenerate

    assign page_o  = ptr_q.page;
    assign mask_o  = mask_q;
    assign bytes_o = buf_q;

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (take_data && ptr_q.pos == POS_W'(PAGE_BYTES-1)) |=> (ptr_q.pos == '0));
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        commit |=> (mask_q == '0));
    p_addr_drop_r2: assert property (@(posedge clk) disable iff (rst)
        take_addr |=> (mask_q == '0));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int WR_CYCLES = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy_o,
    output logic commit_o
);
    localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign commit_o = busy_q && (cnt_q == '0);
    assign busy_o   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(WR_CYCLES - 1);
        end
    end

    p_busy_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_o);
    p_commit_ends_r6: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !busy_o);
endmodule

// File: rtl/pwb_store.sv
module pwb_store
    import pwb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        commit,
    input  logic [PAGE_W-1:0]           page,
    input  logic [PAGE_BYTES-1:0]       mask,
    input  logic [PAGE_BYTES-1:0][7:0]  bytes,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data
);
    logic [7:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= ERASED;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem_q[{page, POS_W'(i)}] <= bytes[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!commit ##1 $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int WR_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_vld,
    input  logic [7:0]        addr,
    input  logic              data_vld,
    input  logic [7:0]        data,
    input  logic              stop_vld,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    strobe_e                     kind;
    logic                        accept, start, commit;
    logic [PAGE_W-1:0]           page;
    logic [PAGE_BYTES-1:0]       mask;
    logic [PAGE_BYTES-1:0][7:0]  bytes;

    assign kind   = pick_strobe(addr_vld, data_vld, stop_vld);
    assign accept = !busy;
    assign start  = accept && (kind == SK_STOP) && (|mask);

    pwb_buffer u_buf (
        .clk(clk), .rst(rst), .kind(kind), .accept(accept),
        .addr(addr), .data(data), .commit(commit),
        .page_o(page), .mask_o(mask), .bytes_o(bytes)
    );

    pwb_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(start),
        .busy_o(busy), .commit_o(commit)
    );

    pwb_store u_mem (
        .clk(clk), .rst(rst), .commit(commit), .page(page),
        .mask(mask), .bytes(bytes), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    p_empty_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && stop_vld && !addr_vld && !data_vld && mask == '0) |=> !busy);
    p_commit_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        commit |-> busy);
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> ($stable(mask) && busy));
endmodule

// File: tb/tb_pwb_top.sv
module tb_pwb_top;
    localparam int WR = 24;

    logic clk = 1'b0, rst = 1'b1;
    logic addr_vld = 0, data_vld = 0, stop_vld = 0;
    logic [7:0] addr = 0, data = 0, rd_addr = 0;
    logic [7:0] rd_data;
    logic busy;

    int n_cmp = 0, n_bad = 0;

    pwb_top #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr(addr),
        .data_vld(data_vld), .data(data), .stop_vld(stop_vld),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #4 clk = ~clk;

    // Behavioural reference
    int m_mem [256];
    int m_buf [16];
    bit [15:0] m_mask;
    bit m_busy;
    int m_cnt, m_page, m_pos;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            foreach (m_buf[i]) m_buf[i] = 0;
            m_mask = 0; m_busy = 0; m_cnt = 0; m_page = 0; m_pos = 0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                for (int i = 0; i < 16; i++) if (m_mask[i]) m_mem[m_page*16 + i] = m_buf[i];
                m_mask = 0; m_busy = 0;
            end else m_cnt--;
        end else if (addr_vld) begin
            m_page = addr / 16; m_pos = addr % 16; m_mask = 0;
        end else if (data_vld) begin
            m_buf[m_pos] = data; m_mask[m_pos] = 1; m_pos = (m_pos + 1) % 16;
        end else if (stop_vld && m_mask != 0) begin
            m_busy = 1; m_cnt = WR;
        end
    end

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            report(busy === m_busy, "R6 busy vs model", busy, m_busy);
            report(rd_data === 8'(m_mem[rd_addr]), "R7 storage vs model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic put_addr(input logic [7:0] a);
        @(negedge clk); addr_vld = 1; addr = a;
        @(negedge clk); addr_vld = 0;
    endtask
    task automatic put_data(input logic [7:0] d);
        @(negedge clk); data_vld = 1; data = d;
        @(negedge clk); data_vld = 0;
    endtask
    task automatic put_stop();
        @(negedge clk); stop_vld = 1;
        @(negedge clk); stop_vld = 0;
    endtask
    task automatic peek(input logic [7:0] a, input int exp, input string tag);
        rd_addr = a; #1;
        report(rd_data === 8'(exp), tag, rd_data, exp);
    endtask
    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        report(busy === 1'b0, "R1 busy after reset", busy, 0);
        peek(8'h00, 255, "R1 erased byte 00");
        peek(8'hFF, 255, "R1 erased byte FF");
        peek(8'h35, 255, "R11 read port");

        // R2/R3/R5/R6/R7 basic write
        put_addr(8'h35); put_data(8'hA1); put_data(8'hB2); put_data(8'hC3);
        put_stop();
        #1 report(busy === 1'b1, "R6 busy after STOP", busy, 1);
        peek(8'h35, 255, "R7 unchanged while busy");
        wait_idle(n);
        report(n == WR, "R6 busy length", n, WR);
        peek(8'h35, 8'hA1, "R2 start position");
        peek(8'h36, 8'hB2, "R3 next position");
        peek(8'h37, 8'hC3, "R3 third position");
        peek(8'h34, 255, "R5 below untouched");
        peek(8'h38, 255, "R5 above untouched");

        // R4/R3 wrap with 18 bytes from 0x7E
        put_addr(8'h7E);
        for (int i = 0; i < 18; i++) put_data(8'(8'h10 + i));
        put_stop(); wait_idle(n);
        peek(8'h70, 8'h12, "R3 wrapped to page start");
        peek(8'h7D, 8'h1F, "R3 last before wrap point");
        peek(8'h7E, 8'h20, "R4 overwrite at E");
        peek(8'h7F, 8'h21, "R4 overwrite at F");
        peek(8'h80, 255, "R3 next page untouched");
        peek(8'h6F, 255, "R3 previous page untouched");

        // R8 empty STOP
        put_addr(8'h10); put_stop();
        #1 report(busy === 1'b0, "R8 empty STOP no busy", busy, 0);

        // R9 strobes ignored while busy
        put_addr(8'h50); put_data(8'h5A); put_stop();
        put_addr(8'h90); put_data(8'h55); put_stop();
        #1 report(busy === 1'b1, "R9 still busy", busy, 1);
        wait_idle(n);
        peek(8'h50, 8'h5A, "R9 prior byte committed");
        peek(8'h90, 255, "R9 ignored address/data");
        peek(8'h51, 255, "R9 ignored data not at 51");
        put_stop();
        #1 report(busy === 1'b0, "R10 STOP after commit idle", busy, 0);

        // R12 priority
        @(negedge clk); addr_vld = 1; addr = 8'hA0; data_vld = 1; data = 8'h11;
        @(negedge clk); addr_vld = 0; data_vld = 0;
        put_data(8'h22); put_stop(); wait_idle(n);
        peek(8'hA0, 8'h22, "R12 address wins");
        peek(8'hA1, 255, "R12 data dropped");

        // R2 discard on new address
        put_addr(8'hC0); put_data(8'h33); put_addr(8'hC8); put_data(8'h44);
        put_stop(); wait_idle(n);
        peek(8'hC0, 255, "R2 discarded byte");
        peek(8'hC8, 8'h44, "R2 new address byte");

        // R10 continue after commit without address
        put_data(8'h66); put_stop(); wait_idle(n);
        peek(8'hC9, 8'h66, "R10 position kept");
        peek(8'hC8, 8'h44, "R5 earlier byte kept");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule